// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

This block holds the translation table of a 32-bit core whose page-table walk is done by software. Each slot keeps a virtual page-pair number (address bits 31..13), an 8-bit address-space identifier, a global flag, a valid flag and three 32-bit words: two page-frame words and a page-size word. Software fills the table with one of two write commands. The indexed write goes to a slot chosen by software. The random write goes to a slot derived from a free-running count, and it never lands in the low "pinned" slots below the pin boundary.

A probe command compares a key word against every slot at once. It loads the result register with the lowest matching slot number, or with a miss code in which only bit 31 is set. A one-cycle done pulse follows every command. A combinational read port shows any slot's stored contents, so that the translation path next to this block can use them.

Top module: `xlat_buffer`

## Requirements
- R1: After reset, `index_out` is 0, `done` is 0 and every slot is invalid with its global flag clear. A probe issued before any write returns the miss code 0x80000000, even for a key of all zeros.
- R2: Command codes on `cmd_op` are: 0 idle, 1 indexed write, 2 random write, 3 probe. An indexed write stores the key, both frame words and the size word in the slot named by `index_in[3:0]`. The upper bits of `index_in`, bit 31 included, are ignored. The stored key reads back as `{key[31:13], 5'b0, key[7:0]}`.
- R3: A random write with `pin_in` below 16 stores into slot `pin_in + (count_in mod (16 - pin_in))`, so no slot below `pin_in` is chosen.
- R4: A random write with `pin_in` of 16 or more stores into slot 15.
- R5: A probe hits a slot that is valid, whose stored page-pair number equals `key_in[31:13]` and whose stored identifier equals `key_in[7:0]`. On a hit `index_out` holds the slot number with bit 31 clear.
- R6: A slot whose global flag is set matches on the page-pair number alone. The flag is set on a write when bit 0 of both frame words is 1.
- R7: A probe that matches no slot loads `index_out` with exactly 0x80000000.
- R8: When several slots match, the probe reports the lowest slot number.
- R9: `done` is high for exactly the one cycle after each non-idle command. `index_out` changes only at the edge that completes a probe.
- R10: Key bits 12..8 take no part in the probe compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command: 0 idle, 1 indexed write, 2 random write, 3 probe |
| key_in | input | 32 | Page-pair number (31..13) and identifier (7..0) for writes and probes |
| frame0_in | input | 32 | Even-page frame word written on a write |
| frame1_in | input | 32 | Odd-page frame word written on a write |
| size_in | input | 32 | Page-size word written on a write |
| pin_in | input | 32 | Pin boundary: slots below it are skipped by random writes |
| count_in | input | 32 | Free-running count that seeds the random slot |
| index_in | input | 32 | Slot selector for the indexed write |
| index_out | output | 32 | Probe result: slot number, or 0x80000000 on a miss |
| done | output | 1 | One-cycle pulse after each command |
| rd_slot | input | 4 | Slot shown on the read port |
| rd_key | output | 32 | Stored key of `rd_slot` |
| rd_frame0 | output | 32 | Stored even frame word of `rd_slot` |
| rd_frame1 | output | 32 | Stored odd frame word of `rd_slot` |
| rd_size | output | 32 | Stored size word of `rd_slot` |

## Verification
Some faults leave a slot holding stale contents or sitting in the wrong place: a wrong random-slot calculation, a lost write enable, or a valid flag that survives reset. These show on the read port in the same cycle the slot is selected. They also show on `index_out` one edge after the next probe whose key targets that slot. A broken priority order or a broken global-flag path stays hidden until two slots share a page-pair number, or until the identifier differs. For that reason the stimulus plants duplicates and foreign identifiers on purpose. Faults in the done or result-hold logic are visible on the first idle cycle after a command.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   // command codes on cmd_op
   typedef enum logic [1:0] {
      XB_IDLE   = 2'd0,
      XB_WR_IDX = 2'd1,
      XB_WR_RND = 2'd2,
      XB_PROBE  = 2'd3
   } xb_op_e;

   localparam int unsigned XB_DW      = 32;
   localparam int unsigned XB_VPN_LSB = 13;
   localparam int unsigned XB_VPN_W   = XB_DW - XB_VPN_LSB;
   localparam int unsigned XB_ASID_W  = 8;
   localparam logic [XB_DW-1:0] XB_MISS = 32'h8000_0000;
endpackage

// File: rtl/xlat_slot_pick.sv
module xlat_slot_pick #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned DW      = 32,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic             rnd,
   input  logic [DW-1:0]    index_in,
   input  logic [DW-1:0]    pin_in,
   input  logic [DW-1:0]    count_in,
   output logic [IDX_W-1:0] slot
);
   localparam logic [DW-1:0] ENT_W = DW'(ENTRIES);

   logic          all_pinned;
   logic [DW-1:0] span;
   logic [DW-1:0] rem;
   logic [DW-1:0] rnd_full;

   assign all_pinned = (pin_in >= ENT_W);
   // span never zero: the pinned-out case is steered away below
   assign span       = all_pinned ? {{(DW-1){1'b0}}, 1'b1} : (ENT_W - pin_in);
   assign rem        = count_in % span;
   assign rnd_full   = pin_in + rem;

   always_comb begin
      if (!rnd)
         slot = index_in[IDX_W-1:0];
      else if (all_pinned)
         slot = IDX_W'(ENTRIES - 1);
      else
         slot = rnd_full[IDX_W-1:0];
   end
endmodule

// File: rtl/xlat_store.sv
module xlat_store #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned DW      = 32,
   parameter int unsigned VPN_W   = 19,
   parameter int unsigned ASID_W  = 8,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  wslot,
   input  logic [VPN_W-1:0]  w_vpn,
   input  logic [ASID_W-1:0] w_asid,
   input  logic              w_glob,
   input  logic [DW-1:0]     w_f0,
   input  logic [DW-1:0]     w_f1,
   input  logic [DW-1:0]     w_size,
   output logic [ENTRIES-1:0] valid,
   output logic [ENTRIES-1:0] glob,
   output logic [VPN_W-1:0]  vpn  [ENTRIES],
   output logic [ASID_W-1:0] asid [ENTRIES],
   output logic [DW-1:0]     f0   [ENTRIES],
   output logic [DW-1:0]     f1   [ENTRIES],
   output logic [DW-1:0]     size [ENTRIES]
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic hit_w;
      assign hit_w = we && (wslot == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid[i] <= 1'b0;
            glob[i]  <= 1'b0;
            vpn[i]   <= '0;
            asid[i]  <= '0;
            f0[i]    <= '0;
            f1[i]    <= '0;
            size[i]  <= '0;
         end else if (hit_w) begin
            valid[i] <= 1'b1;
            glob[i]  <= w_glob;
            vpn[i]   <= w_vpn;
            asid[i]  <= w_asid;
            f0[i]    <= w_f0;
            f1[i]    <= w_f1;
            size[i]  <= w_size;
         end
      end
   end
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned VPN_W   = 19,
   parameter int unsigned ASID_W  = 8,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic [VPN_W-1:0]   p_vpn,
   input  logic [ASID_W-1:0]  p_asid,
   input  logic [ENTRIES-1:0] valid,
   input  logic [ENTRIES-1:0] glob,
   input  logic [VPN_W-1:0]   vpn  [ENTRIES],
   input  logic [ASID_W-1:0]  asid [ENTRIES],
   output logic               hit,
   output logic [IDX_W-1:0]   hit_idx
);
   logic [ENTRIES-1:0] m;

   // one comparator per slot, all in parallel
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign m[i] = valid[i] && (vpn[i] == p_vpn) &&
                    (glob[i] || (asid[i] == p_asid));
   end

   // lowest index wins: scan from the top so the last write is the lowest
   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (m[i]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
   import xlat_pkg::*;
#(
   parameter int unsigned ENTRIES = 16,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_op,
   input  logic [31:0]       key_in,
   input  logic [31:0]       frame0_in,
   input  logic [31:0]       frame1_in,
   input  logic [31:0]       size_in,
   input  logic [31:0]       pin_in,
   input  logic [31:0]       count_in,
   input  logic [31:0]       index_in,
   output logic [31:0]       index_out,
   output logic              done,
   input  logic [IDX_W-1:0]  rd_slot,
   output logic [31:0]       rd_key,
   output logic [31:0]       rd_frame0,
   output logic [31:0]       rd_frame1,
   output logic [31:0]       rd_size
);
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("xlat_buffer: ENTRIES must be a power of two, at least 2");
   end
   if (IDX_W >= 31) begin : g_bad_width
      $error("xlat_buffer: slot number collides with the miss bit");
   end

   xb_op_e op;
   assign op = xb_op_e'(cmd_op);

   logic             we;
   logic [IDX_W-1:0] wr_slot;
   logic             hit;
   logic [IDX_W-1:0] hit_idx;

   logic [ENTRIES-1:0]   valid, glob;
   logic [XB_VPN_W-1:0]  vpn  [ENTRIES];
   logic [XB_ASID_W-1:0] asid [ENTRIES];
   logic [XB_DW-1:0]     f0   [ENTRIES];
   logic [XB_DW-1:0]     f1   [ENTRIES];
   logic [XB_DW-1:0]     sz   [ENTRIES];

   assign we = (op == XB_WR_IDX) || (op == XB_WR_RND);

   xlat_slot_pick #(.ENTRIES(ENTRIES), .DW(XB_DW)) u_pick (
      .rnd      (op == XB_WR_RND),
      .index_in (index_in),
      .pin_in   (pin_in),
      .count_in (count_in),
      .slot     (wr_slot)
   );

   xlat_store #(.ENTRIES(ENTRIES), .DW(XB_DW), .VPN_W(XB_VPN_W),
                .ASID_W(XB_ASID_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .wslot  (wr_slot),
      .w_vpn  (key_in[XB_DW-1:XB_VPN_LSB]),
      .w_asid (key_in[XB_ASID_W-1:0]),
      .w_glob (frame0_in[0] & frame1_in[0]),
      .w_f0   (frame0_in),
      .w_f1   (frame1_in),
      .w_size (size_in),
      .valid  (valid),
      .glob   (glob),
      .vpn    (vpn),
      .asid   (asid),
      .f0     (f0),
      .f1     (f1),
      .size   (sz)
   );

   xlat_match #(.ENTRIES(ENTRIES), .VPN_W(XB_VPN_W),
                .ASID_W(XB_ASID_W)) u_match (
      .p_vpn   (key_in[XB_DW-1:XB_VPN_LSB]),
      .p_asid  (key_in[XB_ASID_W-1:0]),
      .valid   (valid),
      .glob    (glob),
      .vpn     (vpn),
      .asid    (asid),
      .hit     (hit),
      .hit_idx (hit_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_out <= '0;
         done      <= 1'b0;
      end else begin
         done <= (op != XB_IDLE);
         if (op == XB_PROBE)
            index_out <= hit ? XB_DW'(hit_idx) : XB_MISS;
      end
   end

   localparam int unsigned GAP = XB_VPN_LSB - XB_ASID_W;
   assign rd_key    = {vpn[rd_slot], {GAP{1'b0}}, asid[rd_slot]};
   assign rd_frame0 = f0[rd_slot];
   assign rd_frame1 = f1[rd_slot];
   assign rd_size   = sz[rd_slot];
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
   parameter int unsigned ENTRIES = 16,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cmd_op,
   input logic [31:0]      pin_in,
   input logic [31:0]      index_out,
   input logic             done,
   input logic [IDX_W-1:0] wr_slot
);
   AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op != 2'd0) |=> done); // R9
   AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 2'd0) |=> !done); // R9
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op != 2'd3) |=> $stable(index_out)); // R9
   AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      index_out[31] |-> (index_out[30:0] == 31'd0)); // R7
   AST_HIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !index_out[31] |-> (index_out < 32'(ENTRIES))); // R5
   AST_RND_ABOVE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 2'd2 && pin_in < 32'(ENTRIES)) |-> (32'(wr_slot) >= pin_in)); // R3
   AST_RND_ALL_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 2'd2 && pin_in >= 32'(ENTRIES)) |-> (wr_slot == IDX_W'(ENTRIES - 1))); // R4
endmodule

bind xlat_buffer xlat_buffer_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/sim_xlat_buffer.sv
module sim_xlat_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [31:0] key_in = '0, frame0_in = '0, frame1_in = '0, size_in = '0;
   logic [31:0] pin_in = '0, count_in = '0, index_in = '0;
   logic [31:0] index_out;
   logic        done;
   logic [3:0]  rd_slot = '0;
   logic [31:0] rd_key, rd_frame0, rd_frame1, rd_size;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   xlat_buffer u0 (.*);

   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] key;
      logic [31:0] f0;
      logic [31:0] f1;
      logic [7:0]  pin;
      logic [15:0] cnt;
      logic [31:0] idx;
      logic [31:0] exp;   // slot for writes, index_out for probes
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{2'd1, 32'h0040_0005, 32'h100, 32'h200, 8'd0, 16'd0, 32'd3, 32'd3, 8'd2},          // R2
      '{2'd3, 32'h0040_0005, 32'h0, 32'h0, 8'd0, 16'd0, 32'd0, 32'd3, 8'd5},              // R5
      '{2'd3, 32'h0040_0006, 32'h0, 32'h0, 8'd0, 16'd0, 32'd0, 32'h8000_0000, 8'd7},      // R7
      '{2'd3, 32'h0040_1F05, 32'h0, 32'h0, 8'd0, 16'd0, 32'd0, 32'd3, 8'd10},             // R10
      '{2'd1, 32'h0080_0011, 32'h1, 32'h1, 8'd0, 16'd0, 32'd1, 32'd1, 8'd2},              // R2
      '{2'd3, 32'h0080_00AA, 32'h0, 32'h0, 8'd0, 16'd0, 32'd0, 32'd1, 8'd6},              // R6
      '{2'd1, 32'h0040_0005, 32'h300, 32'h302, 8'd0, 16'd0, 32'd7, 32'd7, 8'd2},          // R2
      '{2'd3, 32'h0040_0005, 32'h0, 32'h0, 8'd0, 16'd0, 32'd0, 32'd3, 8'd8},              // R8
      '{2'd2, 32'h0100_0022, 32'h400, 32'h402, 8'd4, 16'd23, 32'd0, 32'd15, 8'd3},        // R3
      '{2'd3, 32'h0100_0022, 32'h0, 32'h0, 8'd0, 16'd0, 32'd0, 32'd15, 8'd3},             // R3
      '{2'd2, 32'h0200_0033, 32'h500, 32'h502, 8'd0, 16'd37, 32'd0, 32'd5, 8'd3},         // R3
      '{2'd3, 32'h0200_0033, 32'h0, 32'h0, 8'd0, 16'd0, 32'd0, 32'd5, 8'd3},              // R3
      '{2'd2, 32'h0300_0044, 32'h600, 32'h602, 8'd20, 16'd9, 32'd0, 32'd15, 8'd4},        // R4
      '{2'd3, 32'h0300_0044, 32'h0, 32'h0, 8'd0, 16'd0, 32'd0, 32'd15, 8'd4},             // R4
      '{2'd3, 32'h0100_0022, 32'h0, 32'h0, 8'd0, 16'd0, 32'd0, 32'h8000_0000, 8'd4},      // R4
      '{2'd2, 32'h0400_0055, 32'h700, 32'h702, 8'd15, 16'd1000, 32'd0, 32'd15, 8'd3},     // R3
      '{2'd1, 32'h0040_0005, 32'h800, 32'h802, 8'd0, 16'd0, 32'h8000_0002, 32'd2, 8'd2},  // R2
      '{2'd3, 32'h0040_0005, 32'h0, 32'h0, 8'd0, 16'd0, 32'd0, 32'd2, 8'd8},              // R8
      '{2'd2, 32'h0500_0066, 32'h900, 32'h901, 8'd6, 16'd10, 32'd0, 32'd6, 8'd3},         // R3
      '{2'd3, 32'h0500_0066, 32'h0, 32'h0, 8'd0, 16'd0, 32'd0, 32'd6, 8'd3}               // R3
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [31:0] key);
      @(negedge clk);
      cmd_op = op;
      key_in = key;
      @(negedge clk);
      cmd_op = 2'd0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL R9: watchdog expired, actual hang expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", index_out, 32'h0);
      chk("R1", {31'd0, done}, 32'h0);
      issue(2'd3, 32'h0000_0000);
      chk("R1", index_out, 32'h8000_0000);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cmd_op    = VEC[i].op;
         key_in    = VEC[i].key;
         frame0_in = VEC[i].f0;
         frame1_in = VEC[i].f1;
         size_in   = {VEC[i].f0[15:0], VEC[i].f1[15:0]};
         pin_in    = 32'(VEC[i].pin);
         count_in  = 32'(VEC[i].cnt);
         index_in  = VEC[i].idx;
         @(negedge clk);
         cmd_op = 2'd0;
         chk("R9", {31'd0, done}, 32'd1);
         if (VEC[i].op == 2'd3) begin
            chk($sformatf("R%0d", VEC[i].req), index_out, VEC[i].exp);
         end else begin
            rd_slot = VEC[i].exp[3:0];
            #1;
            chk($sformatf("R%0d", VEC[i].req), rd_key,
                {VEC[i].key[31:13], 5'd0, VEC[i].key[7:0]});
            chk($sformatf("R%0d", VEC[i].req), rd_frame0, VEC[i].f0);
            chk($sformatf("R%0d", VEC[i].req), rd_size,
                {VEC[i].f0[15:0], VEC[i].f1[15:0]});
         end
      end

      // R9: done drops after one cycle; idle and write leave index_out alone
      @(negedge clk);
      chk("R9", {31'd0, done}, 32'd0);
      key_in = 32'h0300_0044;
      @(negedge clk);
      chk("R9", index_out, 32'd6);
      frame0_in = 32'h0; frame1_in = 32'h0;
      index_in  = 32'd9;
      issue(2'd1, 32'h0600_0077);
      chk("R9", index_out, 32'd6);
      // R7: miss after a hit clears the slot number completely
      issue(2'd3, 32'h0700_0001);
      chk("R7", index_out, 32'h8000_0000);
      // R6: non-global slot 9 does not match a foreign identifier
      issue(2'd3, 32'h0600_0078);
      chk("R6", index_out, 32'h8000_0000);
      issue(2'd3, 32'h0600_0077);
      chk("R5", index_out, 32'd9);

      // R1: a fresh reset invalidates every slot
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      issue(2'd3, 32'h0600_0077);
      chk("R1", index_out, 32'h8000_0000);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule